// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Periodic Interrupts

This block is a calendar real-time clock that sits behind a byte-wide register port. A host uses a 7-bit address, write and read strobes and 8-bit data buses to set and read the time of day and the calendar. The host also sets a time-of-day alarm, picks the rate of a periodic event and square wave, and collects interrupt flags. A tick enable input, nominally 32.768 kHz, drives a prescaler. Once per second an update state machine advances the seconds. The carry then runs through minutes, hours, day of week, day of month (leap years included), month and a two-digit year. Hours count in 24-hour form, or in 12-hour form with bit 7 as the PM marker.

The update state machine has four states. `ST_IDLE` waits for the warning point of the prescaler, which comes `UIP_LEAD` ticks before the end of the second. The transition *arm* goes to `ST_PENDING`, where the update-in-progress flag is raised. *Abort* returns to `ST_IDLE` when software freezes updates or stops the divider. *Commit* at the second boundary goes to `ST_ADVANCE`, where the calendar registers take their next values. *Settle* goes to `ST_CHECK`, which raises the update-ended flag and compares the new time with the alarm. *Release* returns to `ST_IDLE`.

Three event flags (periodic, alarm, update-ended) are set whether or not their interrupts are enabled. A summary flag and the interrupt output are asserted while any flag meets its enable. One read of the flag register returns all the flags and clears them.

Top module: `rtc_core`

## Requirements
- R1: After reset: seconds, minutes, hours and year are 0; day of week, day of month and month are 1; alarms are 0. Control A (0x0A) reads 0x26 and control B (0x0B) reads 0x00. The flag register (0x0C) reads 0x00 and `irq_o` is low. The power register (0x0D) reads `{batt_ok, 7'b0}`.
- R2: Byte addresses 0x00–0x09 hold, in this order: seconds, seconds alarm, minutes, minutes alarm, hours, hours alarm, day of week, day of month, month and year, all binary. Each reads back what was written. Read data appears one cycle after `rd_en`, and addresses above 0x0D read 0x00.
- R3: With divider field A[6:4] = 010, the time advances once every 2^`SEC_W` ticks. The carry runs: seconds 59→0, minutes 59→0, hours 23→0, day of week 7→1, day of month past the last day of the month (February has 29 days when year[1:0] = 00), month 12→1, year 99→0.
- R4: When B[2] = 1, hours follow 12-hour form with bit 7 = PM. 11 AM (0x0B) → 12 PM (0x8C); 12 PM (0x8C) → 1 PM (0x81); 11 PM (0x8B) → 12 AM (0x0C) with a day carry.
- R5: A[7] is read-only. It reads 1 from `UIP_LEAD` ticks before a second boundary until the update completes, and reads 0 otherwise.
- R6: When B[7] = 1, no update starts and any pending update is abandoned, so the time registers hold their values.
- R7: When A[6:4] ≠ 010, the prescaler is held at zero and the time does not advance. Writing 010 starts a full second from zero.
- R8: Rate code A[3:0] = 0 gives neither periodic events nor a square wave. Codes 1 and 2 give periods of 128 and 256 ticks; codes 3–15 give 2^(code−1) ticks. Each period sets the periodic flag C[6]. `sqw_o` is a 50 % square wave of that period while B[3] = 1, and low otherwise.
- R9: The alarm flag C[5] is set after an update when seconds, minutes and hours all equal their alarm registers.
- R10: The update-ended flag C[4] is set at the end of every update.
- R11: C[6:4] are set regardless of enables B[6:4] (periodic, alarm, update-ended). C[7] and `irq_o` are high while any flag is set with its enable, including when the enable is written after the flag.
- R12: A read of 0x0C returns `{C[7:4], 4'b0}`, clears all flags and drops `irq_o`. Writes to 0x0C and 0x0D have no effect.
- R13: B[1] (daylight-saving enable) and the other B bits are stored as written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 7 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered |
| tick_en | input | 1 | Time-base tick enable (32.768 kHz nominal) |
| batt_ok | input | 1 | Backup power good |
| irq_o | output | 1 | Active-high interrupt |
| sqw_o | output | 1 | Square-wave output |

## Verification
The in-RTL assertions check, on every cycle, these rules:
- `ST_ADVANCE` is only entered from a cycle with the update-in-progress flag set.
- A freeze keeps the machine out of `ST_PENDING`.
- A seconds step below 59 adds exactly one.
- A read of the flag register with no new event leaves all flags clear.
- The update-ended flag follows its event.
- `irq_o` never rises without a stored flag.

The calendar carry chain (month lengths, leap February, 12-hour sequencing), the exact timing of the flag window and the full-second restart need the bench's directed scenarios. So do alarm matching, late enabling of an interrupt and the measured duty of the square wave.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PENDING,
        ST_ADVANCE,
        ST_CHECK
    } upd_state_e;

    localparam int N_TIME   = 10;
    localparam int I_SEC    = 0;
    localparam int I_SEC_AL = 1;
    localparam int I_MIN    = 2;
    localparam int I_MIN_AL = 3;
    localparam int I_HOUR   = 4;
    localparam int I_HOUR_AL= 5;
    localparam int I_DOW    = 6;
    localparam int I_DATE   = 7;
    localparam int I_MONTH  = 8;
    localparam int I_YEAR   = 9;
    localparam int I_CTLA   = 10;
    localparam int I_CTLB   = 11;
    localparam int I_FLAGS  = 12;
    localparam int I_POWER  = 13;

    localparam logic [2:0] DIV_RUN   = 3'b010;
    localparam logic [6:0] CTLA_INIT = 7'h26;

    function automatic logic [7:0] month_days(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'd2:                     month_days = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  month_days = 8'd30;
            default:                  month_days = 8'd31;
        endcase
    endfunction

    // returns {day_carry, next_hour}
    function automatic logic [8:0] hour_step(input logic [7:0] hr, input logic mode12);
        logic [6:0] v;
        v = hr[6:0];
        if (!mode12)
            hour_step = (hr >= 8'd23) ? {1'b1, 8'd0} : {1'b0, hr + 8'd1};
        else if (v == 7'd12)
            hour_step = {1'b0, hr[7], 7'd1};
        else if (v == 7'd11)
            hour_step = hr[7] ? {1'b1, 8'h0C} : {1'b0, 8'h8C};
        else
            hour_step = {1'b0, hr[7], v + 7'd1};
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int DIV_W    = 15,
    parameter int SEC_W    = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic [3:0] rate,
    output logic       warn_o,
    output logic       sec_o,
    output logic       per_o,
    output logic       sqw_raw_o
);
    localparam logic [DIV_W-1:0] SEC_MASK = DIV_W'((64'd1 << SEC_W) - 64'd1);
    localparam logic [DIV_W-1:0] WARN_AT  = SEC_MASK - DIV_W'(UIP_LEAD);

    logic [DIV_W-1:0] cnt_q;
    logic [3:0]       tap;
    logic [DIV_W-1:0] per_mask;
    logic             rate_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        case (rate)
            4'd1:    tap = 4'd7;
            4'd2:    tap = 4'd8;
            default: tap = rate - 4'd1;
        endcase
        per_mask = DIV_W'((32'd1 << tap) - 32'd1);
        rate_on  = (rate != 4'd0);
    end

    assign sec_o     = run & tick_en & ((cnt_q & SEC_MASK) == SEC_MASK);
    assign warn_o    = run & tick_en & ((cnt_q & SEC_MASK) == WARN_AT);
    assign per_o     = run & tick_en & rate_on & ((cnt_q & per_mask) == per_mask);
    assign sqw_raw_o = run & rate_on & cnt_q[tap - 4'd1];

endmodule

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warn_i,
    input  logic sec_i,
    input  logic abort_i,
    output logic uip_o,
    output logic adv_o,
    output logic done_o
);
    upd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (warn_i && !abort_i) state_d = ST_PENDING;
            ST_PENDING: if (abort_i)            state_d = ST_IDLE;
                        else if (sec_i)         state_d = ST_ADVANCE;
            ST_ADVANCE:                         state_d = ST_CHECK;
            ST_CHECK:                           state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        uip_o  = (state_q != ST_IDLE);
        adv_o  = (state_q == ST_ADVANCE);
        done_o = (state_q == ST_CHECK);
    end

    p_adv_after_uip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> $past(uip_o));

    p_freeze_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !uip_o) |=> !uip_o);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv_i,
    input  logic                  wr_i,
    input  logic [6:0]            addr_i,
    input  logic [7:0]            data_i,
    input  logic                  mode12_i,
    output logic [N_TIME-1:0][7:0] bank_o,
    output logic                  alarm_hit_o
);
    logic [N_TIME-1:0][7:0] bank_q, step;
    logic [8:0]             hs;
    logic                   carry;

    always_comb begin
        step  = bank_q;
        hs    = '0;
        carry = 1'b0;
        if (bank_q[I_SEC] >= 8'd59) begin
            step[I_SEC] = 8'd0;
            carry       = 1'b1;
        end else begin
            step[I_SEC] = bank_q[I_SEC] + 8'd1;
        end
        if (carry) begin
            if (bank_q[I_MIN] >= 8'd59) step[I_MIN] = 8'd0;
            else begin
                step[I_MIN] = bank_q[I_MIN] + 8'd1;
                carry       = 1'b0;
            end
        end
        if (carry) begin
            hs           = hour_step(bank_q[I_HOUR], mode12_i);
            step[I_HOUR] = hs[7:0];
            carry        = hs[8];
        end
        if (carry) begin
            step[I_DOW] = (bank_q[I_DOW] >= 8'd7) ? 8'd1 : bank_q[I_DOW] + 8'd1;
            if (bank_q[I_DATE] >= month_days(bank_q[I_MONTH], bank_q[I_YEAR])) step[I_DATE] = 8'd1;
            else begin
                step[I_DATE] = bank_q[I_DATE] + 8'd1;
                carry        = 1'b0;
            end
        end
        if (carry) begin
            if (bank_q[I_MONTH] >= 8'd12) step[I_MONTH] = 8'd1;
            else begin
                step[I_MONTH] = bank_q[I_MONTH] + 8'd1;
                carry         = 1'b0;
            end
        end
        if (carry) begin
            step[I_YEAR] = (bank_q[I_YEAR] >= 8'd99) ? 8'd0 : bank_q[I_YEAR] + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q          <= '0;
            bank_q[I_DOW]   <= 8'd1;
            bank_q[I_DATE]  <= 8'd1;
            bank_q[I_MONTH] <= 8'd1;
        end else if (adv_i) begin
            bank_q <= step;
        end else if (wr_i && (addr_i < 7'(N_TIME))) begin
            bank_q[addr_i[3:0]] <= data_i;
        end
    end

    assign bank_o      = bank_q;
    assign alarm_hit_o = (bank_q[I_SEC]  == bank_q[I_SEC_AL]) &&
                         (bank_q[I_MIN]  == bank_q[I_MIN_AL]) &&
                         (bank_q[I_HOUR] == bank_q[I_HOUR_AL]);

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && (bank_q[I_SEC] < 8'd59)) |=> (bank_q[I_SEC] == $past(bank_q[I_SEC]) + 8'd1));

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       per_set_i,
    input  logic       al_set_i,
    input  logic       up_set_i,
    input  logic [2:0] en_i,
    input  logic       clr_i,
    output logic [3:0] flags_o,
    output logic       irq_o
);
    logic pf_q, af_q, uf_q, irqf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            af_q <= 1'b0;
            uf_q <= 1'b0;
        end else begin
            pf_q <= (pf_q & ~clr_i) | per_set_i;
            af_q <= (af_q & ~clr_i) | al_set_i;
            uf_q <= (uf_q & ~clr_i) | up_set_i;
        end
    end

    assign irqf    = |({pf_q, af_q, uf_q} & en_i);
    assign flags_o = {irqf, pf_q, af_q, uf_q};
    assign irq_o   = irqf;

    p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !per_set_i && !al_set_i && !up_set_i) |=> (flags_o == 4'b0000));

    p_uf_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_set_i |=> uf_q);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int SEC_W    = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       tick_en,
    input  logic       batt_ok,
    output logic       irq_o,
    output logic       sqw_o
);
    logic [6:0]             ctl_a;
    logic [7:0]             ctl_b;
    logic                   run, warn, sec_hit, per_hit, sqw_raw;
    logic                   uip, adv, done, alarm_hit, clr;
    logic [3:0]             flags;
    logic [N_TIME-1:0][7:0] bank;
    logic [7:0]             rd_mux;

    assign run = (ctl_a[6:4] == DIV_RUN);
    assign clr = rd_en && (addr == 7'(I_FLAGS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a <= CTLA_INIT;
            ctl_b <= 8'h00;
        end else if (wr_en) begin
            if (addr == 7'(I_CTLA)) ctl_a <= wr_data[6:0];
            if (addr == 7'(I_CTLB)) ctl_b <= wr_data;
        end
    end

    rtc_tick_div #(.DIV_W(DIV_W), .SEC_W(SEC_W), .UIP_LEAD(UIP_LEAD)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .rate(ctl_a[3:0]),
        .warn_o(warn), .sec_o(sec_hit), .per_o(per_hit), .sqw_raw_o(sqw_raw)
    );

    rtc_update_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .warn_i(warn), .sec_i(sec_hit),
        .abort_i(ctl_b[7] | ~run), .uip_o(uip), .adv_o(adv), .done_o(done)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .wr_i(wr_en), .addr_i(addr),
        .data_i(wr_data), .mode12_i(ctl_b[2]), .bank_o(bank), .alarm_hit_o(alarm_hit)
    );

    rtc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .per_set_i(per_hit), .al_set_i(done & alarm_hit),
        .up_set_i(done), .en_i(ctl_b[6:4]), .clr_i(clr), .flags_o(flags), .irq_o(irq_o)
    );

    always_comb begin
        rd_mux = 8'h00;
        if (addr < 7'(N_TIME)) rd_mux = bank[addr[3:0]];
        else if (addr == 7'(I_CTLA))  rd_mux = {uip, ctl_a};
        else if (addr == 7'(I_CTLB))  rd_mux = ctl_b;
        else if (addr == 7'(I_FLAGS)) rd_mux = {flags, 4'b0000};
        else if (addr == 7'(I_POWER)) rd_mux = {batt_ok, 7'b0000000};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign sqw_o = ctl_b[3] & sqw_raw;

    p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags[2:0] != 3'b000));

endmodule

// File: tb/tb_rtc_core.sv
`timescale 1ns/1ps
module tb_rtc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tick_en = 1'b1;
    logic       batt_ok = 1'b1;
    logic       irq_o, sqw_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rtc_core #(.SEC_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tick_en(tick_en), .batt_ok(batt_ok),
        .irq_o(irq_o), .sqw_o(sqw_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Frozen load, then divider restarted from zero by the final write
    task automatic load_time(input logic [7:0] bmode, input logic keep_frozen, input logic [7:0] hr,
                             input logic [7:0] mi, input logic [7:0] se, input logic [7:0] dw,
                             input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
        wr(7'h0B, 8'h80 | bmode);
        wr(7'h00, se); wr(7'h02, mi); wr(7'h04, hr);
        wr(7'h06, dw); wr(7'h07, dt); wr(7'h08, mo); wr(7'h09, yr);
        wr(7'h0A, 8'h00);
        wr(7'h0B, keep_frozen ? (8'h80 | bmode) : bmode);
        wr(7'h0A, 8'h20);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(7'h0C, d); chk("R1 flags after reset", d, 8'h00);
        chk("R1 irq after reset", irq_o, 0);
        rd(7'h0A, d); chk("R1 control A reset", d, 8'h26);
        rd(7'h0B, d); chk("R1 control B reset", d, 8'h00);
        rd(7'h00, d); chk("R1 seconds reset", d, 0);
        rd(7'h04, d); chk("R1 hours reset", d, 0);
        rd(7'h06, d); chk("R1 day of week reset", d, 1);
        rd(7'h07, d); chk("R1 date reset", d, 1);
        rd(7'h08, d); chk("R1 month reset", d, 1);
        rd(7'h09, d); chk("R1 year reset", d, 0);
        rd(7'h0D, d); chk("R1 power good", d, 8'h80);
        batt_ok = 1'b0;
        rd(7'h0D, d); chk("R1 power lost", d, 8'h00);
        batt_ok = 1'b1;
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(7'h0B, 8'h80);
        wr(7'h01, 8'h2A); wr(7'h03, 8'h15); wr(7'h05, 8'h07); wr(7'h09, 8'h42);
        rd(7'h01, d); chk("R2 seconds alarm", d, 8'h2A);
        rd(7'h03, d); chk("R2 minutes alarm", d, 8'h15);
        rd(7'h05, d); chk("R2 hours alarm", d, 8'h07);
        rd(7'h09, d); chk("R2 year", d, 8'h42);
        rd(7'h40, d); chk("R2 unmapped address", d, 8'h00);
        wr(7'h0B, 8'h4E);
        rd(7'h0B, d); chk("R13 control B stored incl. DST bit", d, 8'h4E);
        wr(7'h0B, 8'h00);
    endtask

    task automatic t_ro_regs();
        logic [7:0] d;
        wr(7'h0A, 8'h00); wr(7'h0A, 8'h20);
        rd(7'h0C, d);
        wr(7'h0C, 8'hFF); wr(7'h0D, 8'h00);
        rd(7'h0C, d); chk("R12 write to flags ignored", d, 8'h00);
        rd(7'h0D, d); chk("R12 write to power ignored", d, 8'h80);
    endtask

    task automatic t_rollover();
        logic [7:0] d;
        load_time(8'h00, 1'b0, 8'd23, 8'd59, 8'd59, 8'd7, 8'd31, 8'd12, 8'd99);
        idle(1000);
        rd(7'h00, d); chk("R7 no advance before full second", d, 59);
        idle(40);
        rd(7'h00, d); chk("R3 seconds wrap", d, 0);
        rd(7'h02, d); chk("R3 minutes wrap", d, 0);
        rd(7'h04, d); chk("R3 hours wrap", d, 0);
        rd(7'h06, d); chk("R3 day of week wrap", d, 1);
        rd(7'h07, d); chk("R3 date wrap", d, 1);
        rd(7'h08, d); chk("R3 month wrap", d, 1);
        rd(7'h09, d); chk("R3 year wrap", d, 0);
    endtask

    task automatic t_month_len();
        logic [7:0] d;
        load_time(8'h00, 1'b0, 8'd23, 8'd59, 8'd59, 8'd3, 8'd28, 8'd2, 8'd4);
        idle(1045);
        rd(7'h07, d); chk("R3 leap February 29th", d, 29);
        rd(7'h08, d); chk("R3 leap month held", d, 2);
        load_time(8'h00, 1'b0, 8'd23, 8'd59, 8'd59, 8'd3, 8'd28, 8'd2, 8'd5);
        idle(1045);
        rd(7'h07, d); chk("R3 common February rolls", d, 1);
        rd(7'h08, d); chk("R3 March after February", d, 3);
        load_time(8'h00, 1'b0, 8'd23, 8'd59, 8'd59, 8'd3, 8'd30, 8'd4, 8'd5);
        idle(1045);
        rd(7'h07, d); chk("R3 30-day month rolls", d, 1);
        rd(7'h08, d); chk("R3 May after April", d, 5);
    endtask

    task automatic t_12h();
        logic [7:0] d;
        load_time(8'h04, 1'b0, 8'h0B, 8'd59, 8'd59, 8'd2, 8'd10, 8'd6, 8'd5);
        idle(1045);
        rd(7'h04, d); chk("R4 11AM to 12PM", d, 8'h8C);
        rd(7'h07, d); chk("R4 no day carry at noon", d, 10);
        load_time(8'h04, 1'b0, 8'h8C, 8'd59, 8'd59, 8'd2, 8'd10, 8'd6, 8'd5);
        idle(1045);
        rd(7'h04, d); chk("R4 12PM to 1PM", d, 8'h81);
        load_time(8'h04, 1'b0, 8'h8B, 8'd59, 8'd59, 8'd2, 8'd10, 8'd6, 8'd5);
        idle(1045);
        rd(7'h04, d); chk("R4 11PM to 12AM", d, 8'h0C);
        rd(7'h07, d); chk("R4 day carry at midnight", d, 11);
        wr(7'h0B, 8'h00);
    endtask

    task automatic t_uip();
        logic [7:0] d;
        load_time(8'h00, 1'b0, 8'd1, 8'd2, 8'd3, 8'd1, 8'd1, 8'd1, 8'd1);
        idle(1018);
        rd(7'h0A, d); chk("R5 update flag high near boundary", d, 8'hA0);
        idle(20);
        rd(7'h0A, d); chk("R5 update flag low after update", d, 8'h20);
    endtask

    task automatic t_freeze();
        logic [7:0] d;
        load_time(8'h00, 1'b1, 8'd4, 8'd5, 8'd6, 8'd1, 8'd1, 8'd1, 8'd1);
        idle(1018);
        rd(7'h0A, d); chk("R6 no update flag while frozen", d, 8'h20);
        idle(100);
        rd(7'h00, d); chk("R6 seconds held while frozen", d, 6);
        wr(7'h0B, 8'h00);
    endtask

    task automatic t_div_hold();
        logic [7:0] d;
        load_time(8'h00, 1'b0, 8'd4, 8'd5, 8'd6, 8'd1, 8'd1, 8'd1, 8'd1);
        wr(7'h0A, 8'h86);
        rd(7'h0A, d); chk("R5 bit 7 read-only", d, 8'h06);
        idle(1100);
        rd(7'h00, d); chk("R7 divider stopped holds time", d, 6);
        rd(7'h0A, d); chk("R7 no update flag when stopped", d, 8'h06);
        wr(7'h0A, 8'h20);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        load_time(8'h00, 1'b0, 8'd10, 8'd20, 8'd30, 8'd1, 8'd1, 8'd1, 8'd1);
        wr(7'h01, 8'd31); wr(7'h03, 8'd20); wr(7'h05, 8'd10);
        rd(7'h0C, d);
        idle(1030);
        chk("R11 irq low with enables off", irq_o, 0);
        rd(7'h0C, d); chk("R9 R10 alarm and update flags", d, 8'h30);
        wr(7'h0B, 8'h20); wr(7'h01, 8'd32);
        idle(1015);
        chk("R11 irq with alarm enabled", irq_o, 1);
        rd(7'h0C, d); chk("R11 summary flag set", d, 8'hB0);
        chk("R12 irq drops after flag read", irq_o, 0);
        idle(1024);
        chk("R9 no alarm on mismatch", irq_o, 0);
        rd(7'h0C, d); chk("R9 only update flag on mismatch", d, 8'h10);
        idle(1024);
        chk("R11 irq low before late enable", irq_o, 0);
        wr(7'h0B, 8'h10);
        chk("R11 late enable raises irq", irq_o, 1);
        rd(7'h0C, d); chk("R10 update flag with summary", d, 8'h90);
        wr(7'h0B, 8'h00);
    endtask

    task automatic t_periodic();
        logic [7:0] d;
        wr(7'h0A, 8'h26);
        rd(7'h0C, d);
        idle(40);
        rd(7'h0C, d); chk("R8 periodic flag at rate 6", d & 8'h40, 8'h40);
        wr(7'h0B, 8'h40);
        idle(40);
        chk("R11 periodic irq", irq_o, 1);
        wr(7'h0B, 8'h00);
        wr(7'h0A, 8'h20);
        rd(7'h0C, d);
        idle(100);
        rd(7'h0C, d); chk("R8 rate 0 gives no periodic flag", d & 8'h40, 0);
    endtask

    task automatic count_sqw(output int highs);
        highs = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sqw_o) highs++;
        end
    endtask

    task automatic t_sqw();
        int h;
        wr(7'h0A, 8'h23); wr(7'h0B, 8'h08);
        count_sqw(h); chk("R8 square wave duty rate 3", h, 32);
        wr(7'h0A, 8'h26);
        count_sqw(h); chk("R8 square wave duty rate 6", h, 32);
        wr(7'h0B, 8'h00);
        count_sqw(h); chk("R8 square wave off when disabled", h, 0);
        wr(7'h0B, 8'h08); wr(7'h0A, 8'h20);
        count_sqw(h); chk("R8 square wave off at rate 0", h, 0);
        wr(7'h0B, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ro_regs();
        t_rollover();
        t_month_len();
        t_12h();
        t_uip();
        t_freeze();
        t_div_hold();
        t_alarm();
        t_periodic();
        t_sqw();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R3 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule